// File: doc/BRIEF.md
# Johnson Ring Counter/Divider with Decoded Slots

This block is a synchronous divider built from a twisted-ring (Johnson) shift register. A single compile-time switch sets its size. In decade mode there are five stages and ten time slots. In octal mode there are four stages and eight time slots. On every clock edge that is not held off, the ring moves one position. The position is reported on a one-hot slot vector. Each slot bit comes from a two-input gate on a pair of neighbouring stages. Only one stage changes per step, so the slot outputs cannot glitch.

A carry output runs at one-tenth (or one-eighth) of the clock rate, and its rising edge marks each return to slot 0. Driving the clock of a following stage from the carry builds a ripple chain of decades. A hold input freezes the count. An asynchronous reset forces slot 0.

The ring's feedback includes anti-lock correction. If the stages ever hold a pattern that the normal sequence never produces, the ring falls back into the legal sequence on its own within one pass of the stage count.

Top module: `johnson_divider`

## Requirements
- R1: A high `rst_i` forces slot 0 (`slot_o` equal to 1, bit 0 set) and `carry_o` high at once, without waiting for a clock edge. Reset wins over `hold_i` and over the clock.
- R2: On each rising edge of `clk_i` with `rst_i` low and `hold_i` low, the active slot moves from index k to index k+1.
- R3: On a rising edge with `hold_i` high, `slot_o` and `carry_o` keep their values.
- R4: While the ring is in its legal sequence, exactly one bit of `slot_o` is high, and it stays high for one full clock period per advance.
- R5: The slot after the last one is slot 0: after slot 9 in decade mode (`DECADE`=1), and after slot 7 in octal mode (`DECADE`=0).
- R6: `carry_o` is high in slots 0 to 4 (decade) or 0 to 3 (octal), and low in the others. It therefore rises exactly once per full count, when the count wraps to slot 0.
- R7: From any illegal stage pattern, the ring reaches a legal pattern within a number of advances equal to the stage count. After that, `slot_o` is one-hot again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock; the ring advances on its rising edge |
| rst_i | input | 1 | Asynchronous active-high reset to slot 0 |
| hold_i | input | 1 | Active-high hold; when high, clock edges do not advance the ring |
| slot_o | output | 10 (decade) / 8 (octal) | One-hot decoded time slot; bit k is high in slot k |
| carry_o | output | 1 | Divided output, high during the first half of the count |

## Verification
The bench places a decade instance (`DECADE`=1) and an octal instance (`DECADE`=0) side by side and drives both from the same clock, reset and hold. One stimulus sequence therefore reaches both wrap points, both carry thresholds and the separate rise counts of 8 and 10 over a common run of 80 advances. To reach the anti-lock recovery, the bench loads a non-sequence pattern into each ring. It then observes only the slot ports after the stage count of advances.

// File: rtl/jc_pkg.sv
package jc_pkg;

  // Stage count chosen by the mode switch: five for decade, four for octal.
  function automatic int stage_count(input bit decade);
    return decade ? 5 : 4;
  endfunction

  // A ring pattern is legal when, reading bit 0 upward over the first n
  // bits, the value changes at most once.
  function automatic logic ring_legal(input logic [7:0] q, input int n);
    int edges;
    edges = 0;
    for (int i = 1; i < 8; i++) begin
      if (i < n && q[i] != q[i-1]) edges++;
    end
    return (edges <= 1);
  endfunction

endpackage

// File: rtl/jc_ring.sv
module jc_ring #(
  parameter int STAGES = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  output logic [STAGES-1:0] stage_o
);
  localparam int CW = $clog2(STAGES + 2);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic              mid_clear;
  logic              feed;

  // Anti-lock feedback. A new run of ones may start only from the all-zero
  // pattern; otherwise the lowest run is extended or closed. Any stray run
  // is pushed out of the top within STAGES shifts.
  always_comb begin
    mid_clear = ~|stage_q[STAGES-2:1];
    feed      = ~stage_q[STAGES-1] & (stage_q[0] | mid_clear);
    stage_d   = {stage_q[STAGES-2:0], feed};
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)      stage_q <= '0;
    else if (adv_i) stage_q <= stage_d;
  end

  assign stage_o = stage_q;

  // Recovery window, counted at advancing edges that see an illegal pattern.
  logic          legal_now;
  logic [CW-1:0] bad_cnt;

  assign legal_now = jc_pkg::ring_legal({{(8-STAGES){1'b0}}, stage_q}, STAGES);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)          bad_cnt <= '0;
    else if (legal_now) bad_cnt <= '0;
    else if (adv_i)     bad_cnt <= bad_cnt + 1'b1;
  end

  // R7: an illegal pattern never survives more than STAGES advances
  p_recover_in_window_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    bad_cnt <= CW'(STAGES));

  // R1: while reset is high the ring sits at the zero pattern
  p_reset_clears_r1: assert property (@(posedge clk_i)
    rst_i |-> (stage_q == '0));

endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0]   stage_i,
  output logic [2*STAGES-1:0] slot_o,
  output logic                carry_o
);
  localparam int SLOTS = 2 * STAGES;

  // Each slot is a two-input gate on neighbouring stages.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k == 0) begin : g_first
      assign slot_o[k] = ~stage_i[STAGES-1] & ~stage_i[0];
    end else if (k < STAGES) begin : g_fill
      assign slot_o[k] = stage_i[k-1] & ~stage_i[k];
    end else if (k == STAGES) begin : g_full
      assign slot_o[k] = stage_i[STAGES-1] & stage_i[0];
    end else begin : g_drain
      assign slot_o[k] = ~stage_i[k-STAGES-1] & stage_i[k-STAGES];
    end
  end

  // Carry is high while the top stage is still clear (the first half).
  assign carry_o = ~stage_i[STAGES-1];

endmodule

// File: rtl/johnson_divider.sv
module johnson_divider #(
  parameter bit DECADE = 1'b1
) (
  input  logic                                    clk_i,
  input  logic                                    rst_i,
  input  logic                                    hold_i,
  output logic [2*jc_pkg::stage_count(DECADE)-1:0] slot_o,
  output logic                                    carry_o
);
  localparam int STAGES = jc_pkg::stage_count(DECADE);
  localparam int SLOTS  = 2 * STAGES;

  logic [STAGES-1:0] stage_w;
  logic              adv;
  logic              ring_ok;

  assign adv = ~hold_i;

  jc_ring #(.STAGES(STAGES)) u_ring (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .adv_i   (adv),
    .stage_o (stage_w)
  );

  jc_decode #(.STAGES(STAGES)) u_decode (
    .stage_i (stage_w),
    .slot_o  (slot_o),
    .carry_o (carry_o)
  );

  assign ring_ok = jc_pkg::ring_legal({{(8-STAGES){1'b0}}, stage_w}, STAGES);

  // R4: a legal ring gives exactly one active slot
  p_one_slot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ring_ok |-> ($countones(slot_o) == 1));

  // R1: reset shows slot 0 and a high carry
  p_reset_slot_r1: assert property (@(posedge clk_i)
    rst_i |-> (slot_o[0] && carry_o));

  // R3: a held edge leaves the outputs unchanged
  p_hold_freeze_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_i |=> ($stable(slot_o) || !ring_ok));

  // R6: carry rises only on entry to slot 0
  p_carry_wrap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (ring_ok && $rose(carry_o)) |-> slot_o[0]);

  // R2, R5: each slot hands over to the next, the last one to slot 0
  for (genvar k = 0; k < SLOTS; k++) begin : g_step_chk
    p_slot_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (ring_ok && !hold_i && slot_o[k]) |=> (slot_o[(k+1)%SLOTS] || !ring_ok || rst_i));
  end

endmodule

// File: tb/test_johnson_divider.sv
`timescale 1ns/1ps
module test_johnson_divider;
  logic       clk;
  logic       rst;
  logic       hold;
  logic [9:0] slot_dec;
  logic [7:0] slot_oct;
  logic       carry_dec;
  logic       carry_oct;
  int         checks = 0;
  int         fails  = 0;

  johnson_divider #(.DECADE(1'b1)) i_johnson_divider (
    .clk_i(clk), .rst_i(rst), .hold_i(hold), .slot_o(slot_dec), .carry_o(carry_dec));

  johnson_divider #(.DECADE(1'b0)) i_johnson_divider_oct (
    .clk_i(clk), .rst_i(rst), .hold_i(hold), .slot_o(slot_oct), .carry_o(carry_oct));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {rst, hold, expected decade slot[3:0], expected octal slot[2:0]}
  localparam logic [8:0] VEC [20] = '{
    9'b0_0_0001_001, 9'b0_0_0010_010, 9'b0_1_0010_010, 9'b0_0_0011_011,
    9'b0_0_0100_100, 9'b0_0_0101_101, 9'b0_0_0110_110, 9'b0_0_0111_111,
    9'b0_0_1000_000, 9'b0_1_1000_000, 9'b0_0_1001_001, 9'b0_0_0000_010,
    9'b0_0_0001_011, 9'b1_0_0000_000, 9'b1_1_0000_000, 9'b0_0_0001_001,
    9'b0_1_0001_001, 9'b0_1_0001_001, 9'b0_0_0010_010, 9'b0_0_0011_011
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic h);
    rst  = r;
    hold = h;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_both(input string tag, input int d, input int o);
    chk({tag, " decade slot"}, 32'(slot_dec), 32'(10'(1) << d));
    chk({tag, " octal slot"},  32'(slot_oct), 32'(8'(1) << o));
    chk("R6 decade carry", 32'(carry_dec), 32'(d < 5));
    chk("R6 octal carry",  32'(carry_oct), 32'(o < 4));
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst  = 1'b1;
    hold = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check_both("R1 reset", 0, 0);
    rst = 1'b0;

    for (int i = 0; i < 20; i++) begin
      logic       vr;
      logic       vh;
      int         ed;
      int         eo;
      vr = VEC[i][8];
      vh = VEC[i][7];
      ed = int'(VEC[i][6:3]);
      eo = int'(VEC[i][2:0]);
      step(vr, vh);
      if (vr)                     check_both("R1 reset priority", ed, eo);
      else if (vh)                check_both("R3 hold", ed, eo);
      else if (ed == 0 || eo == 0) check_both("R5 wrap", ed, eo);
      else                        check_both("R2 advance", ed, eo);
    end

    // R1: asynchronous reset between edges
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    #0.5;
    rst = 1'b1;
    #0.5;
    chk("R1 async decade", 32'(slot_dec), 32'd1);
    chk("R1 async octal",  32'(slot_oct), 32'd1);
    @(negedge clk);
    rst = 1'b0;

    // R6, R4: 80 advances, counting carry rises and one-hot slots
    begin
      int  rise_d;
      int  rise_o;
      int  bad_hot;
      logic pd;
      logic po;
      rise_d  = 0;
      rise_o  = 0;
      bad_hot = 0;
      pd = carry_dec;
      po = carry_oct;
      for (int n = 0; n < 80; n++) begin
        step(1'b0, 1'b0);
        if (carry_dec && !pd) rise_d++;
        if (carry_oct && !po) rise_o++;
        if ($countones(slot_dec) != 1 || $countones(slot_oct) != 1) bad_hot++;
        pd = carry_dec;
        po = carry_oct;
      end
      chk("R6 decade carry rises", 32'(rise_d), 32'd8);
      chk("R6 octal carry rises",  32'(rise_o), 32'd10);
      chk("R4 one-hot over run",   32'(bad_hot), 32'd0);
    end

    // R7: inject non-sequence patterns and watch the ports recover
    force i_johnson_divider.u_ring.stage_q     = 5'b01010;
    force i_johnson_divider_oct.u_ring.stage_q = 4'b0101;
    #0.1;
    release i_johnson_divider.u_ring.stage_q;
    release i_johnson_divider_oct.u_ring.stage_q;
    for (int n = 0; n < 5; n++) step(1'b0, 1'b0);
    chk("R7 decade recovered", 32'($countones(slot_dec)), 32'd1);
    chk("R7 octal recovered",  32'($countones(slot_oct)), 32'd1);
    step(1'b1, 1'b0);
    check_both("R1 reset after recovery", 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule